// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small 16-bit accumulator processor. It runs each instruction as a fixed sequence of register transfers. Five registers sit on one internal bus: the accumulator, the program counter, the instruction register, the memory address register and the memory buffer register. In any cycle only one source drives the bus. An instruction is read in two fetch cycles. One to seven execute cycles follow, and their number depends on the opcode. The core drives a synchronous, word-addressed memory. The memory captures the address on a clock edge and returns the read word in the following cycle. A `halted` output tells the environment when the program has stopped.

The instruction set has the usual direct operations: load, store, add, subtract, jump, conditional skip and halt. It also has operand-through-pointer forms of load, store, add and jump. Each pointer form reads memory twice: first to get a pointer, then to use the word the pointer names. A subroutine call saves the return address in the target word and continues at the word after it. A clear instruction zeroes the accumulator. There are no I/O registers and no interrupts.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low, the core holds PC, AC and the halted flag at zero, keeps `mem_we` low and presents address 0, so the first fetch comes from word 0.
- R2: Each instruction word is read from the address held in PC, and PC then advances by one. The opcode is bits 15:12 and the operand address X is bits 11:0. Encodings: call=0, load=1, store=2, add=3, subtract=4, halt=7, skip=8, jump=9, clear=A, add-through-pointer=B, jump-through-pointer=C, load-through-pointer=D, store-through-pointer=E. Codes 5, 6 and F do nothing.
- R3: Direct load sets AC to M[X]. Direct store sets M[X] to AC. Direct add sets AC to AC+M[X], and subtract sets AC to AC−M[X]. Both wrap modulo 2^16.
- R4: Load-through-pointer sets AC to M[M[X]].
- R5: Store-through-pointer writes AC to M[M[X]] and leaves M[X] unchanged.
- R6: Add-through-pointer sets AC to AC+M[M[X]], modulo 2^16.
- R7: Jump-through-pointer continues execution at address M[X].
- R8: The call instruction at address A with operand X writes A+1 into M[X], leaves AC equal to X+1 and continues execution at X+1.
- R9: Clear sets AC to zero.
- R10: Skip tests IR bits 11:10. Code 00 skips the next word when AC is negative (two's complement). Code 01 skips when AC is zero. Code 10 skips when AC is positive. Code 11 never skips.
- R11: Halt sets `halted`. `halted` stays set until reset. After it is set, the core writes no memory and holds the memory address steady.
- R12: An instruction occupies 2 fetch cycles plus its execute steps. Direct load, store, add and subtract take 5 cycles. Load, store and add through a pointer take 7. Jump-through-pointer takes 5. Call takes 9. Clear, jump, skip and halt take 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Word address presented to memory on this clock edge |
| mem_we | output | 1 | Write strobe for the word at `mem_addr` |
| mem_wdata | output | 16 | Write data (the memory buffer register) |
| mem_rdata | input | 16 | Word at the address presented on the previous edge |
| halted | output | 1 | Sticky stop flag |

## Verification
The core's memory address is the value the address register will hold after the edge. Read data is therefore valid one cycle after the step that loads the address register, and a value read from memory lands in a register one edge later. Architectural results show up only through memory and `halted`. For that reason the bench runs complete programs and checks memory after `halted` rises, which happens at the edge ending the halt instruction's execute step. It counts every edge from reset release up to that point and compares the count with the total computed from the R12 per-instruction cycle costs. This pins down the sequencing to the exact cycle. Sweeps over array length, operand pairs and every skip code against signed accumulator values cover the arithmetic and the branch corner cases.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam logic [3:0] OP_JNS    = 4'h0;
    localparam logic [3:0] OP_LOAD   = 4'h1;
    localparam logic [3:0] OP_STORE  = 4'h2;
    localparam logic [3:0] OP_ADD    = 4'h3;
    localparam logic [3:0] OP_SUBT   = 4'h4;
    localparam logic [3:0] OP_HALT   = 4'h7;
    localparam logic [3:0] OP_SKIP   = 4'h8;
    localparam logic [3:0] OP_JUMP   = 4'h9;
    localparam logic [3:0] OP_CLEAR  = 4'hA;
    localparam logic [3:0] OP_ADDI   = 4'hB;
    localparam logic [3:0] OP_JUMPI  = 4'hC;
    localparam logic [3:0] OP_LOADI  = 4'hD;
    localparam logic [3:0] OP_STOREI = 4'hE;

    typedef enum logic [2:0] {
        BUS_NONE,
        BUS_PC,
        BUS_IRA,
        BUS_MBR,
        BUS_AC,
        BUS_MEM
    } bus_src_e;

    typedef enum logic [2:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_CLR,
        ALU_ONE
    } alu_op_e;

    typedef enum logic [1:0] {
        PH_FETCH_A,
        PH_FETCH_B,
        PH_EXEC,
        PH_STOP
    } phase_e;

    typedef struct packed {
        bus_src_e src;
        alu_op_e  alu;
        logic     ld_mar;
        logic     ld_mbr;
        logic     ld_ir;
        logic     ld_pc;
        logic     ld_ac;
        logic     pc_inc;
        logic     mem_we;
        logic     last;
        logic     halt;
    } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] bus,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        case (op)
            ALU_ADD: y = acc + bus;
            ALU_SUB: y = acc - bus;
            ALU_CLR: y = '0;
            ALU_ONE: y = DATA_W'(1);
            default: y = bus;
        endcase
    end
endmodule

// File: rtl/acc_cpu_skip.sv
module acc_cpu_skip #(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        cond,
    input  logic [DATA_W-1:0] acc,
    output logic              hit
);
    logic neg, zero;

    always_comb begin
        neg  = acc[DATA_W-1];
        zero = (acc == '0);
        case (cond)
            2'b00:   hit = neg;
            2'b01:   hit = zero;
            2'b10:   hit = !neg && !zero;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  phase_e            phase,
    input  logic [STEP_W-1:0] step,
    input  logic [3:0]        opc,
    input  logic              skip_hit,
    output ctrl_t             ctrl
);
    always_comb begin
        ctrl        = '0;
        ctrl.src    = BUS_NONE;
        ctrl.alu    = ALU_PASS;
        case (phase)
            PH_FETCH_A: begin
                ctrl.src    = BUS_PC;
                ctrl.ld_mar = 1'b1;
            end
            PH_FETCH_B: begin
                ctrl.src    = BUS_MEM;
                ctrl.ld_ir  = 1'b1;
                ctrl.pc_inc = 1'b1;
            end
            PH_EXEC: begin
                case (opc)
                    OP_LOAD, OP_ADD, OP_SUBT: begin
                        case (step)
                            3'd0: begin ctrl.src = BUS_IRA; ctrl.ld_mar = 1'b1; end
                            3'd1: begin ctrl.src = BUS_MEM; ctrl.ld_mbr = 1'b1; end
                            default: begin
                                ctrl.src   = BUS_MBR;
                                ctrl.ld_ac = 1'b1;
                                ctrl.alu   = (opc == OP_LOAD) ? ALU_PASS :
                                             (opc == OP_ADD)  ? ALU_ADD : ALU_SUB;
                                ctrl.last  = 1'b1;
                            end
                        endcase
                    end
                    OP_STORE: begin
                        case (step)
                            3'd0: begin ctrl.src = BUS_IRA; ctrl.ld_mar = 1'b1; end
                            3'd1: begin ctrl.src = BUS_AC;  ctrl.ld_mbr = 1'b1; end
                            default: begin
                                ctrl.src    = BUS_MBR;
                                ctrl.mem_we = 1'b1;
                                ctrl.last   = 1'b1;
                            end
                        endcase
                    end
                    OP_LOADI, OP_ADDI, OP_STOREI, OP_JUMPI: begin
                        case (step)
                            3'd0: begin ctrl.src = BUS_IRA; ctrl.ld_mar = 1'b1; end
                            3'd1: begin ctrl.src = BUS_MEM; ctrl.ld_mbr = 1'b1; end
                            3'd2: begin
                                ctrl.src = BUS_MBR;
                                if (opc == OP_JUMPI) begin
                                    ctrl.ld_pc = 1'b1;
                                    ctrl.last  = 1'b1;
                                end else begin
                                    ctrl.ld_mar = 1'b1;
                                end
                            end
                            3'd3: begin
                                ctrl.src    = (opc == OP_STOREI) ? BUS_AC : BUS_MEM;
                                ctrl.ld_mbr = 1'b1;
                            end
                            default: begin
                                ctrl.src  = BUS_MBR;
                                ctrl.last = 1'b1;
                                if (opc == OP_STOREI) begin
                                    ctrl.mem_we = 1'b1;
                                end else begin
                                    ctrl.ld_ac = 1'b1;
                                    ctrl.alu   = (opc == OP_ADDI) ? ALU_ADD : ALU_PASS;
                                end
                            end
                        endcase
                    end
                    OP_JNS: begin
                        case (step)
                            3'd0: begin ctrl.src = BUS_PC;  ctrl.ld_mbr = 1'b1; end
                            3'd1: begin ctrl.src = BUS_IRA; ctrl.ld_mar = 1'b1; end
                            3'd2: begin ctrl.src = BUS_MBR; ctrl.mem_we = 1'b1; end
                            3'd3: begin ctrl.src = BUS_IRA; ctrl.ld_mbr = 1'b1; end
                            3'd4: begin ctrl.alu = ALU_ONE; ctrl.ld_ac  = 1'b1; end
                            3'd5: begin
                                ctrl.src   = BUS_MBR;
                                ctrl.alu   = ALU_ADD;
                                ctrl.ld_ac = 1'b1;
                            end
                            default: begin
                                ctrl.src   = BUS_AC;
                                ctrl.ld_pc = 1'b1;
                                ctrl.last  = 1'b1;
                            end
                        endcase
                    end
                    OP_HALT: begin
                        ctrl.halt = 1'b1;
                        ctrl.last = 1'b1;
                    end
                    OP_SKIP: begin
                        ctrl.pc_inc = skip_hit;
                        ctrl.last   = 1'b1;
                    end
                    OP_JUMP: begin
                        ctrl.src   = BUS_IRA;
                        ctrl.ld_pc = 1'b1;
                        ctrl.last  = 1'b1;
                    end
                    OP_CLEAR: begin
                        ctrl.alu   = ALU_CLR;
                        ctrl.ld_ac = 1'b1;
                        ctrl.last  = 1'b1;
                    end
                    default: ctrl.last = 1'b1;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 12,
    parameter int MAX_STEPS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);
    localparam int OPC_W  = DATA_W - ADDR_W;
    localparam int STEP_W = $clog2(MAX_STEPS);
    localparam int PAD_W  = DATA_W - ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] ac;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ir;
        phase_e            phase;
        logic [STEP_W-1:0] step;
        logic              halted;
    } core_t;

    core_t             s_q, s_d;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] alu_y;
    logic              skip_hit;
    logic [OPC_W-1:0]  opc;

    assign opc = s_q.ir[DATA_W-1 -: OPC_W];

    acc_cpu_ctrl #(.STEP_W(STEP_W)) u_ctrl (
        .phase    (s_q.phase),
        .step     (s_q.step),
        .opc      (opc),
        .skip_hit (skip_hit),
        .ctrl     (ctrl)
    );

    acc_cpu_skip #(.DATA_W(DATA_W)) u_skip (
        .cond (s_q.ir[ADDR_W-1 -: 2]),
        .acc  (s_q.ac),
        .hit  (skip_hit)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (ctrl.alu),
        .acc (s_q.ac),
        .bus (bus),
        .y   (alu_y)
    );

    // shared bus: exactly one source per cycle
    always_comb begin
        case (ctrl.src)
            BUS_PC:  bus = {{PAD_W{1'b0}}, s_q.pc};
            BUS_IRA: bus = {{PAD_W{1'b0}}, s_q.ir[ADDR_W-1:0]};
            BUS_MBR: bus = s_q.mbr;
            BUS_AC:  bus = s_q.ac;
            BUS_MEM: bus = mem_rdata;
            default: bus = '0;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (ctrl.ld_mar) s_d.mar = bus[ADDR_W-1:0];
        if (ctrl.ld_mbr) s_d.mbr = bus;
        if (ctrl.ld_ir)  s_d.ir  = bus;
        if (ctrl.ld_ac)  s_d.ac  = alu_y;
        if (ctrl.ld_pc)  s_d.pc  = bus[ADDR_W-1:0];
        if (ctrl.pc_inc) s_d.pc  = s_q.pc + ADDR_W'(1);
        case (s_q.phase)
            PH_FETCH_A: s_d.phase = PH_FETCH_B;
            PH_FETCH_B: begin
                s_d.phase = PH_EXEC;
                s_d.step  = '0;
            end
            PH_EXEC: begin
                if (ctrl.halt) begin
                    s_d.phase  = PH_STOP;
                    s_d.halted = 1'b1;
                end else if (ctrl.last) begin
                    s_d.phase = PH_FETCH_A;
                    s_d.step  = '0;
                end else begin
                    s_d.step = s_q.step + STEP_W'(1);
                end
            end
            default: s_d.phase = PH_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_FETCH_A;
        end else begin
            s_q <= s_d;
        end
    end

    // memory sees the address register's next value, so read data
    // is ready in the step after the address register is loaded
    assign mem_addr  = s_d.mar;
    assign mem_we    = ctrl.mem_we;
    assign mem_wdata = bus;
    assign halted    = s_q.halted;

    assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> !mem_we && !halted);
    assert_pc_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase == PH_FETCH_B |=> s_q.pc == $past(s_q.pc) + ADDR_W'(1));
    assert_ir_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase == PH_FETCH_B |=> s_q.ir == $past(mem_rdata));
    assert_write_in_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> s_q.phase == PH_EXEC);
    assert_ret_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_EXEC && opc == OP_JNS && s_q.step == STEP_W'(2))
        |-> mem_we && mem_wdata == {{PAD_W{1'b0}}, s_q.pc});
    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    assert_halt_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);
    assert_halt_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(mem_addr));
    assert_step_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase == PH_EXEC |-> int'(s_q.step) < MAX_STEPS);
endmodule

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        halted;

    logic        ld_we = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] mem [4096];

    int n_chk = 0;
    int n_fail = 0;
    int halt_writes = 0;

    always #10 clk = ~clk;

    acc_cpu_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    always_ff @(posedge clk) begin
        if (!rst_n && ld_we)      mem[ld_addr] <= ld_data;
        else if (rst_n && mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) if (rst_n && halted && mem_we) halt_writes++;

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] x);
        return {op, x};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        ld_addr = a; ld_data = d; ld_we = 1'b1;
        @(posedge clk); #1;
        ld_we = 1'b0;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 halted in reset", 32'(halted), 0);
        chk("R1 no write in reset", 32'(mem_we), 0);
        chk("R1 first address", 32'(mem_addr), 0);
    endtask

    task automatic run(output int cyc);
        @(negedge clk);
        rst_n = 1'b1;
        halt_writes = 0;
        cyc = 0;
        while (!halted && cyc < 5000) begin
            @(posedge clk); #1;
            cyc++;
        end
        if (!halted) chk("R11 watchdog timeout", 32'(cyc), 0);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        // array summation loop, lengths 1..7
        for (int n = 1; n <= 7; n++) begin
            int sum;
            hold_reset();
            poke(12'h000, ins(4'h9, 12'h100));
            poke(12'h100, ins(4'h1, 12'h111));
            poke(12'h101, ins(4'h2, 12'h112));
            poke(12'h102, ins(4'h1, 12'h113));
            poke(12'h103, ins(4'h4, 12'h116));
            poke(12'h104, ins(4'h2, 12'h115));
            poke(12'h105, ins(4'h1, 12'h114));
            poke(12'h106, ins(4'hB, 12'h112));
            poke(12'h107, ins(4'h2, 12'h114));
            poke(12'h108, ins(4'h1, 12'h112));
            poke(12'h109, ins(4'h3, 12'h116));
            poke(12'h10A, ins(4'h2, 12'h112));
            poke(12'h10B, ins(4'h1, 12'h115));
            poke(12'h10C, ins(4'h4, 12'h116));
            poke(12'h10D, ins(4'h2, 12'h115));
            poke(12'h10E, ins(4'h8, 12'h000));
            poke(12'h10F, ins(4'h9, 12'h105));
            poke(12'h110, ins(4'h7, 12'h000));
            poke(12'h111, 16'h0117);
            poke(12'h112, 16'h0000);
            poke(12'h113, 16'(n));
            poke(12'h114, 16'h0000);
            poke(12'h115, 16'h0000);
            poke(12'h116, 16'h0001);
            sum = 0;
            for (int k = 0; k < 7; k++) begin
                poke(12'h117 + 12'(k), 16'(10 * k + 7));
                if (k < n) sum += 10 * k + 7;
            end
            run(cyc);
            chk("R6 array sum", 32'(mem[12'h114]), 32'(sum));
            chk("R3 pointer advanced", 32'(mem[12'h112]), 32'(12'h117 + 12'(n)));
            chk("R10 counter ended negative", 32'(mem[12'h115]), 32'hFFFF);
            chk("R12 cycle total", 32'(cyc), 32'(53 * n + 28));
            chk("R11 halted", 32'(halted), 1);
        end

        // pointer forms, call and clear over operand pairs
        for (int p = 0; p < 4; p++) begin
            logic [15:0] a, b;
            a = (p == 0) ? 16'h0005 : (p == 1) ? 16'h1234 : (p == 2) ? 16'hFFFF : 16'h8000;
            b = (p == 0) ? 16'h0003 : (p == 1) ? 16'h4321 : (p == 2) ? 16'h0001 : 16'h8000;
            hold_reset();
            poke(12'h000, ins(4'hD, 12'h040));
            poke(12'h001, ins(4'hE, 12'h041));
            poke(12'h002, ins(4'hA, 12'h000));
            poke(12'h003, ins(4'h2, 12'h061));
            poke(12'h004, ins(4'h1, 12'h050));
            poke(12'h005, ins(4'hB, 12'h042));
            poke(12'h006, ins(4'h2, 12'h062));
            poke(12'h007, ins(4'h0, 12'h070));
            poke(12'h008, ins(4'h7, 12'h000));
            poke(12'h020, ins(4'h2, 12'h064));
            poke(12'h021, ins(4'h7, 12'h000));
            poke(12'h040, 16'h0050);
            poke(12'h041, 16'h0060);
            poke(12'h042, 16'h0051);
            poke(12'h043, 16'h0020);
            poke(12'h050, a);
            poke(12'h051, b);
            poke(12'h060, 16'h0000);
            poke(12'h061, 16'h5555);
            poke(12'h062, 16'h0000);
            poke(12'h063, 16'h0000);
            poke(12'h064, 16'h0000);
            poke(12'h065, 16'h0BAD);
            poke(12'h070, 16'h0000);
            poke(12'h071, ins(4'h2, 12'h063));
            poke(12'h072, ins(4'hC, 12'h043));
            poke(12'h073, ins(4'h2, 12'h065));
            run(cyc);
            chk("R4 R5 load then store via pointer", 32'(mem[12'h060]), 32'(a));
            chk("R5 pointer word kept", 32'(mem[12'h041]), 32'h0060);
            chk("R9 clear", 32'(mem[12'h061]), 0);
            chk("R6 add via pointer", 32'(mem[12'h062]), 32'(16'(a + b)));
            chk("R8 return word", 32'(mem[12'h070]), 32'h0008);
            chk("R8 accumulator after call", 32'(mem[12'h063]), 32'h0071);
            chk("R7 jump via pointer target", 32'(mem[12'h064]), 32'h0071);
            chk("R7 no fall through", 32'(mem[12'h065]), 32'h0BAD);
            chk("R12 cycle total", 32'(cyc), 32'(7 + 7 + 3 + 5 + 5 + 7 + 5 + 9 + 5 + 5 + 5 + 3));
        end

        // skip codes against signed accumulator values
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 5; v++) begin
                logic [15:0] val;
                logic        skip;
                val = (v == 0) ? 16'h8000 : (v == 1) ? 16'hFFFF : (v == 2) ? 16'h0000 :
                      (v == 3) ? 16'h0001 : 16'h7FFF;
                skip = (c == 0) ? val[15] : (c == 1) ? (val == 0) :
                       (c == 2) ? (!val[15] && val != 0) : 1'b0;
                hold_reset();
                poke(12'h000, ins(4'h1, 12'h030));
                poke(12'h001, ins(4'h8, {2'(c), 10'h000}));
                poke(12'h002, ins(4'h2, 12'h031));
                poke(12'h003, ins(4'h7, 12'h000));
                poke(12'h030, val);
                poke(12'h031, 16'hDEAD);
                run(cyc);
                chk("R10 skip outcome", 32'(mem[12'h031]), skip ? 32'hDEAD : 32'(val));
                chk("R12 skip timing", 32'(cyc), skip ? 32'(5 + 3 + 3) : 32'(5 + 3 + 5 + 3));
            end
        end

        // halt stays and stays quiet; unused opcodes do nothing
        hold_reset();
        poke(12'h000, ins(4'h5, 12'h010));
        poke(12'h001, ins(4'h6, 12'h010));
        poke(12'h002, ins(4'hF, 12'h010));
        poke(12'h003, ins(4'h1, 12'h011));
        poke(12'h004, ins(4'h4, 12'h012));
        poke(12'h005, ins(4'h2, 12'h013));
        poke(12'h006, ins(4'h7, 12'h000));
        poke(12'h007, ins(4'h2, 12'h010));
        poke(12'h010, 16'h1111);
        poke(12'h011, 16'h0003);
        poke(12'h012, 16'h0005);
        poke(12'h013, 16'h0000);
        run(cyc);
        chk("R2 unused codes cost 3 cycles", 32'(cyc), 32'(9 + 5 + 5 + 5 + 3));
        chk("R3 subtract wraps", 32'(mem[12'h013]), 32'hFFFE);
        repeat (40) @(posedge clk);
        #1;
        chk("R11 halt sticky", 32'(halted), 1);
        chk("R11 no writes after halt", 32'(halt_writes), 0);
        chk("R11 next word not run", 32'(mem[12'h010]), 32'h1111);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule